// File: doc/BRIEF.md
# DMA Request Front-End with Demand and Handshake Protocols

This block stands in front of one DMA channel core. It turns a request into a one-cycle start pulse for a single atomic transfer and drives an acknowledge back to the requester. The request comes either from one of several hardware request lines, picked by a source-select field, or from a software trigger strobe. A mode bit chooses between the hardware lines and the software trigger. The channel core reports the end of each atomic transfer on `xfer_done`. Address generation and data movement stay in the core.

Hardware requests pass through a two-stage synchroniser before the block acts on them. A sync-select bit sets how that synchroniser advances. With the bit at 1 it advances on every clock, which suits requesters on the fast system bus. With the bit at 0 it advances only on cycles marked by `slow_tick`, which marks the edges of the slower peripheral clock. Two acknowledge protocols are available. In demand mode, a request that is still high is accepted again as soon as the acknowledge has dropped. In handshake mode, the requester must first withdraw its request.

Top module: `dma_req_frontend`

## Requirements
- R1: After reset, `req_ack` and `xfer_start` are 0.
- R2: In hardware mode (`cfg_hw_mode`=1) only line `hw_req[cfg_src_sel]` can start a transfer; a request on any other line gives no start pulse and no acknowledge.
- R3: With `cfg_sync_fast`=1, a hardware request that rises between clock edges produces `xfer_start`=1 after exactly the third rising edge, and not before.
- R4: With `cfg_sync_fast`=0, the synchroniser advances only on edges where `slow_tick`=1; without ticks a held request never starts a transfer, and the start follows the edge after the second tick.
- R5: `xfer_start` is high for exactly one cycle, and `req_ack` rises on the same edge as `xfer_start`.
- R6: `req_ack` stays high until `xfer_done` is sampled high, and falls on that edge.
- R7: In demand mode (`cfg_handshake`=0), a request still held high is accepted again: `req_ack` is low for exactly one cycle and then a new start pulse follows.
- R8: In handshake mode (`cfg_handshake`=1), a request held high after `xfer_done` starts nothing; a new start needs the synchronised request to go low first and then high again.
- R9: In software mode (`cfg_hw_mode`=0) the hardware lines are ignored; a one-cycle `sw_trig` strobe produces `xfer_start` after the second rising edge.
- R10: While `cfg_enable`=0, neither hardware requests nor software triggers start a transfer.
- R11: A software trigger strobe that arrives while `req_ack` is high is discarded; no start follows after the transfer ends.
- R12: No start pulse occurs while `req_ack` is high from an earlier start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_enable | input | 1 | Channel enable; requests are ignored when 0 |
| cfg_hw_mode | input | 1 | 1 selects hardware request lines, 0 selects the software trigger |
| cfg_handshake | input | 1 | 1 selects the handshake protocol, 0 selects the demand protocol |
| cfg_sync_fast | input | 1 | 1 advances the synchroniser every clock, 0 only on `slow_tick` |
| cfg_src_sel | input | 3 | Index of the hardware request line in use |
| slow_tick | input | 1 | One-cycle strobe that marks a slow-domain clock edge |
| hw_req | input | 8 | Hardware request lines |
| sw_trig | input | 1 | Software trigger write strobe |
| xfer_done | input | 1 | Core reports the end of the atomic transfer |
| xfer_start | output | 1 | One-cycle start pulse for one atomic transfer |
| req_ack | output | 1 | Acknowledge to the requester |

## Verification
The assertions assume that the core asserts `xfer_done` only while `req_ack` is high, and that the configuration inputs stay stable during a transfer. The bench follows both rules. It pulses `xfer_done` only after it has seen an acknowledge, and it changes the configuration only while the block is idle with every request low. All stimulus changes on the falling edge, so each request rises between rising edges, as R3 and R4 expect.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

    localparam int unsigned REQ_LINES   = 8;
    localparam int unsigned SEL_W       = $clog2(REQ_LINES);
    localparam int unsigned SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_DRAIN = 2'd2
    } hs_state_e;

    typedef struct packed {
        logic             enable;
        logic             hw_mode;
        logic             handshake;
        logic             sync_fast;
        logic [SEL_W-1:0] src_sel;
    } fe_cfg_t;

    function automatic logic pick_request(input logic hw_mode,
                                          input logic hw_synced,
                                          input logic sw_pulse);
        return hw_mode ? hw_synced : sw_pulse;
    endfunction

    function automatic logic wants_drain(input logic hw_mode,
                                         input logic handshake);
        return hw_mode & handshake;
    endfunction

endpackage

// File: rtl/dreq_select.sv
module dreq_select
    import dma_req_pkg::*;
#(
    parameter int unsigned LINES = REQ_LINES,
    localparam int unsigned SW   = $clog2(LINES)
) (
    input  logic [LINES-1:0] lines,
    input  logic [SW-1:0]    sel,
    output logic             picked
);
    logic [LINES-1:0] gated;

    for (genvar i = 0; i < LINES; i++) begin : g_gate
        assign gated[i] = lines[i] & (sel == SW'(i));
    end

    assign picked = |gated;
endmodule

// File: rtl/dreq_sync.sv
module dreq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic advance,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else if (advance) begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dreq_ack_fsm.sv
module dreq_ack_fsm
    import dma_req_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic drain_mode,
    input  logic req,
    input  logic hw_level,
    input  logic done,
    output logic start,
    output logic ack
);
    hs_state_e state_q, state_d;
    logic      start_d, ack_d;

    always_comb begin
        state_d = state_q;
        start_d = 1'b0;
        ack_d   = ack;
        unique case (state_q)
            ST_IDLE: begin
                if (enable && req) begin
                    start_d = 1'b1;
                    ack_d   = 1'b1;
                    state_d = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (done) begin
                    ack_d   = 1'b0;
                    state_d = drain_mode ? ST_DRAIN : ST_IDLE;
                end
            end
            ST_DRAIN: begin
                if (!hw_level) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                ack_d   = 1'b0;
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            start   <= 1'b0;
            ack     <= 1'b0;
        end else begin
            state_q <= state_d;
            start   <= start_d;
            ack     <= ack_d;
        end
    end
endmodule

// File: rtl/dma_req_frontend.sv
module dma_req_frontend
    import dma_req_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_enable,
    input  logic                 cfg_hw_mode,
    input  logic                 cfg_handshake,
    input  logic                 cfg_sync_fast,
    input  logic [SEL_W-1:0]     cfg_src_sel,
    input  logic                 slow_tick,
    input  logic [REQ_LINES-1:0] hw_req,
    input  logic                 sw_trig,
    input  logic                 xfer_done,
    output logic                 xfer_start,
    output logic                 req_ack
);
    fe_cfg_t cfg;
    logic    raw_req, synced_req, sw_pulse_q, sync_adv;

    assign cfg = '{enable:    cfg_enable,
                   hw_mode:   cfg_hw_mode,
                   handshake: cfg_handshake,
                   sync_fast: cfg_sync_fast,
                   src_sel:   cfg_src_sel};

    assign sync_adv = cfg.sync_fast | slow_tick;

    dreq_select #(.LINES(REQ_LINES)) sel_i (
        .lines  (hw_req),
        .sel    (cfg.src_sel),
        .picked (raw_req)
    );

    dreq_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .advance (sync_adv),
        .d       (raw_req),
        .q       (synced_req)
    );

    // software trigger bit: set by the write strobe, gone one clock later
    always_ff @(posedge clk) begin
        if (rst) sw_pulse_q <= 1'b0;
        else     sw_pulse_q <= sw_trig;
    end

    dreq_ack_fsm fsm_i (
        .clk        (clk),
        .rst        (rst),
        .enable     (cfg.enable),
        .drain_mode (wants_drain(cfg.hw_mode, cfg.handshake)),
        .req        (pick_request(cfg.hw_mode, synced_req, sw_pulse_q)),
        .hw_level   (synced_req),
        .done       (xfer_done),
        .start      (xfer_start),
        .ack        (req_ack)
    );
endmodule

// File: rtl/dma_req_frontend_chk.sv
module dma_req_frontend_chk (
    input logic clk,
    input logic rst,
    input logic cfg_enable,
    input logic xfer_done,
    input logic xfer_start,
    input logic req_ack
);
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        xfer_start |=> !xfer_start);                               // R5
    AST_ACK_WITH_START: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> req_ack);                                   // R5
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (rst)
        (req_ack && !xfer_done) |=> req_ack);                      // R6
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (req_ack && xfer_done) |=> !req_ack);                      // R6
    AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !xfer_start);                                  // R12
    AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(req_ack) |-> $past(cfg_enable));                     // R10
endmodule

bind dma_req_frontend dma_req_frontend_chk chk_i (.*);

// File: tb/dma_req_frontend_tb_top.sv
module dma_req_frontend_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 0, rst = 1;
    logic       cfg_enable = 0, cfg_hw_mode = 1, cfg_handshake = 0, cfg_sync_fast = 1;
    logic [2:0] cfg_src_sel = 0;
    logic       slow_tick = 0, sw_trig = 0, xfer_done = 0;
    logic [7:0] hw_req = 0;
    logic       xfer_start, req_ack;

    int errors = 0, checks = 0, starts = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_req_frontend dut_i (.*);

    always @(negedge clk) if (xfer_start) starts++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_xfer();
        xfer_done = 1; cyc(1); xfer_done = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int s0;
        cyc(3);
        chk(req_ack == 0 && xfer_start == 0, "R1 reset outputs", {req_ack, xfer_start}, 0);
        rst = 0; cfg_enable = 1;
        cyc(2);

        // R2 sweep: every select value against every request line
        for (int sel = 0; sel < 8; sel++) begin
            for (int ln = 0; ln < 8; ln++) begin
                int exp;
                cfg_src_sel = 3'(sel);
                exp = (sel == ln) ? 1 : 0;
                s0 = starts;
                hw_req = 8'(1 << ln);
                cyc(4);
                chk(starts - s0 == exp && req_ack == exp, "R2 source select", starts - s0, exp);
                hw_req = 0;
                cyc(3);
                if (req_ack) finish_xfer();
                cyc(2);
            end
        end

        // R3 / R5 / R6 fast synchroniser timing and ack hold
        cfg_src_sel = 3'd5;
        hw_req = 8'h20;
        cyc(1); chk(xfer_start == 0, "R3 no start after edge 1", xfer_start, 0);
        cyc(1); chk(xfer_start == 0, "R3 no start after edge 2", xfer_start, 0);
        cyc(1); chk(xfer_start == 1, "R3 start after edge 3", xfer_start, 1);
        chk(req_ack == 1, "R5 ack rises with start", req_ack, 1);
        cyc(1); chk(xfer_start == 0, "R5 start single cycle", xfer_start, 0);
        cyc(4); chk(req_ack == 1, "R6 ack held until done", req_ack, 1);

        // R7 demand: request still high
        finish_xfer();
        chk(req_ack == 0 && xfer_start == 0, "R7 ack low one cycle", req_ack, 0);
        cyc(1); chk(xfer_start == 1 && req_ack == 1, "R7 demand restart", xfer_start, 1);
        hw_req = 0; cyc(3); finish_xfer(); cyc(3);

        // R8 handshake
        cfg_handshake = 1;
        s0 = starts;
        hw_req = 8'h20; cyc(4);
        chk(starts - s0 == 1, "R8 first start", starts - s0, 1);
        finish_xfer(); cyc(6);
        chk(starts - s0 == 1 && req_ack == 0, "R8 held request blocked", starts - s0, 1);
        hw_req = 0; cyc(5);
        chk(starts - s0 == 1, "R8 no start on drop", starts - s0, 1);
        hw_req = 8'h20; cyc(4);
        chk(starts - s0 == 2, "R8 new request accepted", starts - s0, 2);
        hw_req = 0; cyc(3); finish_xfer(); cyc(4);
        cfg_handshake = 0;

        // R4 slow synchroniser
        cfg_sync_fast = 0;
        s0 = starts;
        hw_req = 8'h20; cyc(8);
        chk(starts - s0 == 0, "R4 no tick no start", starts - s0, 0);
        slow_tick = 1; cyc(1); slow_tick = 0; cyc(2);
        slow_tick = 1; cyc(1); slow_tick = 0;
        chk(xfer_start == 0, "R4 no start at second tick", xfer_start, 0);
        cyc(1); chk(xfer_start == 1, "R4 start after second tick", xfer_start, 1);
        hw_req = 0;
        slow_tick = 1; cyc(2); slow_tick = 0;
        finish_xfer(); cyc(3);
        cfg_sync_fast = 1;

        // R9 software mode
        cfg_hw_mode = 0;
        hw_req = 8'hFF;
        s0 = starts; cyc(6);
        chk(starts - s0 == 0, "R9 hw lines ignored", starts - s0, 0);
        sw_trig = 1; cyc(1); sw_trig = 0;
        chk(xfer_start == 0, "R9 no start after edge 1", xfer_start, 0);
        cyc(1); chk(xfer_start == 1, "R9 start after edge 2", xfer_start, 1);

        // R11 trigger during busy discarded
        cyc(2); sw_trig = 1; cyc(1); sw_trig = 0; cyc(2);
        finish_xfer(); s0 = starts; cyc(5);
        chk(starts - s0 == 0 && req_ack == 0, "R11 busy trigger dropped", starts - s0, 0);
        hw_req = 0; cyc(3);

        // R10 disabled channel
        cfg_enable = 0;
        s0 = starts;
        sw_trig = 1; cyc(1); sw_trig = 0; cyc(4);
        chk(starts - s0 == 0, "R10 sw ignored when disabled", starts - s0, 0);
        cfg_hw_mode = 1; cfg_src_sel = 3'd2; hw_req = 8'h04; cyc(6);
        chk(starts - s0 == 0 && req_ack == 0, "R10 hw ignored when disabled", starts - s0, 0);
        hw_req = 0; cyc(4);

        summary();
    end
endmodule